// File: doc/BRIEF.md
# Oscillation-Test Configuration Sequencer

This block controls the production test of an analog amplifier/filter stage that switches into oscillator configurations to be tested. It drives five analog switch controls. At rest the switches hold the functional (normal) setting. After a start request, the block optionally checks its own measurement path against an internal reference square wave. It then steps the switches through three oscillator configurations, one after the other. For each configuration it waits a programmable settle time and then counts rising edges of the squared oscillator output over a programmable gate window.

Each count is compared with a band derived from a programmable nominal count. The band is asymmetric and differs for each configuration, and the limits come from fixed-point constant multiplications, so no divider is needed. A count of zero means the oscillation was lost and is always a fault. At the end the block returns the switches to normal, pulses `done` and holds one fail bit per configuration until the next start.

Top module: `osc_test_seq`

## Requirements
- R1: Out of reset and whenever `busy` is low (except for the single `done` cycle), `sw_ctrl` equals the normal encoding 5'b10100. Reset leaves `busy`=0, `done`=0, `fail_vec`=0 and `st_fail`=0. The `sw_ctrl` bits are: bit0 input select (0 signal, 1 ground), bit1 feedback select (0 ground, 1 second amplifier output), bit2 switch three closed, bit3 switch four closed, bit4 switch five closed.
- R2: A run drives `sw_ctrl` through exactly 5'b10111 (configuration A), then 5'b00111 (configuration B), then 5'b01001 (configuration C), then back to 5'b10100.
- R3: After every switch change, edges are ignored for `settle_cycles` cycles. After that a gate of `gate_cycles` cycles opens, and `sw_ctrl` does not change while the gate is open.
- R4: `osc_in` passes through a two-flop synchroniser, and the block counts its rising edges inside the gate. The counter saturates at all ones.
- R5: With nominal N, a configuration passes when floor(N*L/1024) <= count <= floor(N*H/1024). The constants are L=978, H=1085 for A; L=981, H=1080 for B; L=947, H=1054 for C.
- R6: A count of zero fails the configuration even if the band would include zero.
- R7: `fail_vec` bit0, bit1 and bit2 report A, B and C (1 = fail). `done` is a one-cycle pulse at the end of the run. `fail_vec` holds its value until the next accepted start.
- R8: With `self_test` high at start, a self phase runs first with the switches left at normal. In this phase the counter measures an internal square wave with a period of 4 cycles, whatever `osc_in` does. The phase passes when the count is within +/-1 of `gate_cycles`>>2. A failure sets `st_fail`, sets `fail_vec` to 3'b111 and ends the run.
- R9: `start` is ignored while a run is in progress; the run length and the single `done` pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| self_test | input | 1 | Prepend the self-check phase |
| settle_cycles | input | SETTLE_W | Wait after each switch change |
| gate_cycles | input | GATE_W | Measurement window length |
| nom_cfg_a | input | CNT_W | Nominal count, configuration A |
| nom_cfg_b | input | CNT_W | Nominal count, configuration B |
| nom_cfg_c | input | CNT_W | Nominal count, configuration C |
| osc_in | input | 1 | Squared oscillator output, asynchronous |
| sw_ctrl | output | 5 | Analog switch controls |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail_vec | output | 3 | Per-configuration fail flags |
| st_fail | output | 1 | Self-check failed |

## Verification
The bench places each nominal count so that the asymmetric bands split. The same nominal passes A and B but fails C on the high side, and fails A and B but passes C on the low side. A design that swapped constants or used symmetric limits would return the wrong vector. A burst of fast toggles follows each switch change; a design that opened the gate before the settle time ended would count it and fail every configuration. Dead oscillation with a zero nominal exposes a design that accepts a zero count. A self-test run with a dead `osc_in` exposes a measurement path that does not use the internal reference. A second start during a run exposes a restart through a longer run or an extra `done`.

// File: rtl/osc_seq_pkg.sv
// Shared types and constants for the oscillation-test sequencer.
// Assumes: three oscillator configurations, band constants in 1/1024 units.
package osc_seq_pkg;

    localparam int unsigned FRAC_BITS = 10;
    localparam int unsigned K_W       = 11;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETTLE, ST_GATE, ST_JUDGE, ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_SELF, PH_A, PH_B, PH_C
    } phase_e;

    localparam logic [4:0] SW_NORMAL = 5'b10100;
    localparam logic [4:0] SW_CFG_A  = 5'b10111;
    localparam logic [4:0] SW_CFG_B  = 5'b00111;
    localparam logic [4:0] SW_CFG_C  = 5'b01001;

    // Lower band constant per configuration index (A, B, C).
    function automatic int unsigned lo_k(int unsigned idx);
        case (idx)
            0:       return 978;
            1:       return 981;
            default: return 947;
        endcase
    endfunction

    // Upper band constant per configuration index (A, B, C).
    function automatic int unsigned hi_k(int unsigned idx);
        case (idx)
            0:       return 1085;
            1:       return 1080;
            default: return 1054;
        endcase
    endfunction

    // Switch encoding applied during a phase.
    function automatic logic [4:0] sw_for(phase_e ph);
        case (ph)
            PH_A:    return SW_CFG_A;
            PH_B:    return SW_CFG_B;
            PH_C:    return SW_CFG_C;
            default: return SW_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/osc_edge_counter.sv
// Synchronises the oscillator (or the internal reference) and counts
// rising edges while enabled. Assumes osc_in is asynchronous and slower
// than clk/2. The count saturates at all ones.
module osc_edge_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_ref,
    input  logic             osc_in,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count
);

    logic [1:0] ref_div;
    logic       src;
    logic       s_meta, s_sync, s_prev;
    logic       rise;

    // Free-running divider: reference square wave of period 4.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_div <= '0;
        else        ref_div <= ref_div + 2'd1;
    end

    assign src = use_ref ? ref_div[1] : osc_in;

    // Two-flop synchroniser plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) {s_meta, s_sync, s_prev} <= 3'b000;
        else        {s_meta, s_sync, s_prev} <= {src, s_meta, s_sync};
    end

    assign rise = s_sync & ~s_prev;

    // Saturating edge counter, cleared during the settle wait.
    always_ff @(posedge clk) begin
        if (!rst_n)                      count <= '0;
        else if (clr)                    count <= '0;
        else if (en && rise && ~&count)  count <= count + 1'b1;
    end

endmodule

// File: rtl/osc_band_check.sv
// Derives per-configuration count limits from the nominal counts with
// constant multiplies and judges the current count. Assumes the
// nominal counts are stable for the whole run.
module osc_band_check
    import osc_seq_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned GATE_W = 20
) (
    input  phase_e             phase,
    input  logic [3*CNT_W-1:0] nom_flat,
    input  logic [CNT_W-1:0]   count,
    input  logic [GATE_W-1:0]  gate_cycles,
    output logic               pass
);

    localparam int unsigned PW = CNT_W + K_W;
    localparam int unsigned LW = PW - FRAC_BITS;
    localparam int unsigned EW = ((CNT_W > GATE_W) ? CNT_W : GATE_W) + 2;

    logic [LW-1:0] lo_lim [3];
    logic [LW-1:0] hi_lim [3];

    // One pair of constant multipliers per configuration.
    for (genvar gi = 0; gi < 3; gi++) begin : g_lim
        logic [PW-1:0] lo_p, hi_p;
        assign lo_p = PW'(nom_flat[gi*CNT_W +: CNT_W]) * PW'(lo_k(gi));
        assign hi_p = PW'(nom_flat[gi*CNT_W +: CNT_W]) * PW'(hi_k(gi));
        assign lo_lim[gi] = lo_p[PW-1:FRAC_BITS];
        assign hi_lim[gi] = hi_p[PW-1:FRAC_BITS];
    end

    logic [LW-1:0] cnt_l, lo_sel, hi_sel;
    logic [EW-1:0] cnt_e, exp_e;
    logic          band_ok, self_ok;

    // Select the active limits and judge band or self-check.
    always_comb begin
        case (phase)
            PH_B:    begin lo_sel = lo_lim[1]; hi_sel = hi_lim[1]; end
            PH_C:    begin lo_sel = lo_lim[2]; hi_sel = hi_lim[2]; end
            default: begin lo_sel = lo_lim[0]; hi_sel = hi_lim[0]; end
        endcase
        cnt_l   = LW'(count);
        band_ok = (count != '0) && (cnt_l >= lo_sel) && (cnt_l <= hi_sel);
        cnt_e   = EW'(count);
        exp_e   = EW'(gate_cycles >> 2);
        self_ok = (cnt_e + EW'(1) >= exp_e) && (cnt_e <= exp_e + EW'(1));
        pass    = (phase == PH_SELF) ? self_ok : band_ok;
    end

endmodule

// File: rtl/osc_seq_ctrl.sv
// Run sequencer: self phase (optional), then configurations A, B, C,
// each with a settle wait, a gate window and a one-cycle judgement.
// Assumes settle_cycles and gate_cycles are stable during a run;
// a zero value lasts one cycle.
module osc_seq_ctrl
    import osc_seq_pkg::*;
#(
    parameter int unsigned SETTLE_W = 16,
    parameter int unsigned GATE_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                self_test,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GATE_W-1:0]   gate_cycles,
    input  logic                judge_pass,
    output phase_e              phase,
    output logic                cnt_clr,
    output logic                cnt_en,
    output logic                use_ref,
    output logic [4:0]          sw_ctrl,
    output logic                busy,
    output logic                done,
    output logic [2:0]          fail_vec,
    output logic                st_fail
);

    localparam int unsigned TW = ((SETTLE_W > GATE_W) ? SETTLE_W : GATE_W) + 1;

    seq_state_e    state;
    logic [TW-1:0] timer;
    logic [TW-1:0] limit;
    logic          last;

    // Timer end condition for the current wait.
    always_comb begin
        limit = (state == ST_SETTLE) ? TW'(settle_cycles) : TW'(gate_cycles);
        last  = (timer + TW'(1)) >= limit;
    end

    // Main state machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_A;
            timer    <= '0;
            fail_vec <= 3'b000;
            st_fail  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    fail_vec <= 3'b000;
                    st_fail  <= 1'b0;
                    phase    <= self_test ? PH_SELF : PH_A;
                    timer    <= '0;
                    state    <= ST_SETTLE;
                end
                ST_SETTLE: begin
                    timer <= last ? '0 : timer + TW'(1);
                    if (last) state <= ST_GATE;
                end
                ST_GATE: begin
                    timer <= last ? '0 : timer + TW'(1);
                    if (last) state <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    timer <= '0;
                    case (phase)
                        PH_SELF: begin
                            if (!judge_pass) begin
                                st_fail  <= 1'b1;
                                fail_vec <= 3'b111;
                                state    <= ST_FINISH;
                            end else begin
                                phase <= PH_A;
                                state <= ST_SETTLE;
                            end
                        end
                        PH_A: begin
                            fail_vec[0] <= ~judge_pass;
                            phase       <= PH_B;
                            state       <= ST_SETTLE;
                        end
                        PH_B: begin
                            fail_vec[1] <= ~judge_pass;
                            phase       <= PH_C;
                            state       <= ST_SETTLE;
                        end
                        default: begin
                            fail_vec[2] <= ~judge_pass;
                            state       <= ST_FINISH;
                        end
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from the registered state.
    always_comb begin
        busy    = (state == ST_SETTLE) || (state == ST_GATE) || (state == ST_JUDGE);
        done    = (state == ST_FINISH);
        cnt_clr = (state == ST_SETTLE);
        cnt_en  = (state == ST_GATE);
        use_ref = (phase == PH_SELF);
        sw_ctrl = busy ? sw_for(phase) : SW_NORMAL;
    end

endmodule

// File: rtl/osc_test_seq.sv
// Top of the oscillation-test sequencer: joins the sequencer, the edge
// counter and the band checker. Assumes osc_in is a squared,
// asynchronous oscillator signal.
module osc_test_seq
    import osc_seq_pkg::*;
#(
    parameter int unsigned CNT_W    = 16,
    parameter int unsigned SETTLE_W = 16,
    parameter int unsigned GATE_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                self_test,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic [GATE_W-1:0]   gate_cycles,
    input  logic [CNT_W-1:0]    nom_cfg_a,
    input  logic [CNT_W-1:0]    nom_cfg_b,
    input  logic [CNT_W-1:0]    nom_cfg_c,
    input  logic                osc_in,
    output logic [4:0]          sw_ctrl,
    output logic                busy,
    output logic                done,
    output logic [2:0]          fail_vec,
    output logic                st_fail
);

    phase_e           phase;
    logic             cnt_clr, cnt_en, use_ref, judge_pass;
    logic [CNT_W-1:0] count;

    osc_seq_ctrl #(
        .SETTLE_W(SETTLE_W),
        .GATE_W  (GATE_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .self_test    (self_test),
        .settle_cycles(settle_cycles),
        .gate_cycles  (gate_cycles),
        .judge_pass   (judge_pass),
        .phase        (phase),
        .cnt_clr      (cnt_clr),
        .cnt_en       (cnt_en),
        .use_ref      (use_ref),
        .sw_ctrl      (sw_ctrl),
        .busy         (busy),
        .done         (done),
        .fail_vec     (fail_vec),
        .st_fail      (st_fail)
    );

    osc_edge_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .use_ref(use_ref),
        .osc_in (osc_in),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .count  (count)
    );

    osc_band_check #(
        .CNT_W (CNT_W),
        .GATE_W(GATE_W)
    ) u_band (
        .phase      (phase),
        .nom_flat   ({nom_cfg_c, nom_cfg_b, nom_cfg_a}),
        .count      (count),
        .gate_cycles(gate_cycles),
        .pass       (judge_pass)
    );

endmodule

// File: rtl/osc_test_seq_chk.sv
// Protocol checker for osc_test_seq, bound to every instance.
module osc_test_seq_chk
    import osc_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [4:0] sw_ctrl,
    input logic       busy,
    input logic       done,
    input logic [2:0] fail_vec,
    input logic       st_fail,
    input logic       cnt_en
);

    p_idle_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sw_ctrl == SW_NORMAL);

    p_sw_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ctrl == SW_NORMAL) || (sw_ctrl == SW_CFG_A) ||
        (sw_ctrl == SW_CFG_B)  || (sw_ctrl == SW_CFG_C));

    p_sw_steady_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en && $past(cnt_en) |-> $stable(sw_ctrl));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(fail_vec));

    p_self_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done && st_fail |-> fail_vec == 3'b111);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> busy || done);

endmodule

bind osc_test_seq osc_test_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .sw_ctrl (sw_ctrl),
    .busy    (busy),
    .done    (done),
    .fail_vec(fail_vec),
    .st_fail (st_fail),
    .cnt_en  (cnt_en)
);

// File: tb/osc_test_seq_bench.sv
// Directed bench for osc_test_seq: one task per scenario.
module osc_test_seq_bench;

    localparam int SETTLE = 200;
    localparam int GATE   = 2000;
    localparam logic [4:0] E_NORM = 5'b10100;
    localparam logic [4:0] E_A    = 5'b10111;
    localparam logic [4:0] E_B    = 5'b00111;
    localparam logic [4:0] E_C    = 5'b01001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        self_test = 1'b0;
    logic [15:0] settle_cycles = 16'(SETTLE);
    logic [19:0] gate_cycles = 20'(GATE);
    logic [15:0] nom_cfg_a = 16'd500, nom_cfg_b = 16'd500, nom_cfg_c = 16'd500;
    logic        osc_in = 1'b0;
    logic [4:0]  sw_ctrl;
    logic        busy, done, st_fail;
    logic [2:0]  fail_vec;

    int n_checks = 0;
    int n_fail   = 0;
    int osc_mode = 0;   // 0 live, 1 dead, 2 dead in configuration B
    int done_cnt = 0;
    int ref_len  = 0;
    int last_len = 0;
    logic [4:0] sw_log [8];
    int         log_n = 0;
    logic [4:0] log_last = 5'b10100;

    osc_test_seq u_osc_test_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .self_test(self_test),
        .settle_cycles(settle_cycles), .gate_cycles(gate_cycles),
        .nom_cfg_a(nom_cfg_a), .nom_cfg_b(nom_cfg_b), .nom_cfg_c(nom_cfg_c),
        .osc_in(osc_in), .sw_ctrl(sw_ctrl), .busy(busy), .done(done),
        .fail_vec(fail_vec), .st_fail(st_fail)
    );

    always #10 clk = ~clk;   // 50 MHz

    // Oscillator model: burst of fast toggles after each switch change
    // (must be hidden by the settle wait), then a period-4 square wave.
    int         burst = 0;
    int         div   = 0;
    logic [4:0] seen_sw = 5'b10100;
    always @(negedge clk) begin
        if (sw_ctrl !== seen_sw) begin
            seen_sw = sw_ctrl;
            burst   = 150;
        end
        if (burst > 0) begin
            osc_in = ~osc_in;
            burst  = burst - 1;
        end else if (osc_mode == 1 || (osc_mode == 2 && sw_ctrl == E_B)) begin
            osc_in = 1'b0;
        end else begin
            div    = div + 1;
            osc_in = div[1];
        end
    end

    // Records the switch encodings seen and counts done pulses.
    always @(negedge clk) begin
        if (sw_ctrl !== log_last) begin
            if (log_n < 8) sw_log[log_n] = sw_ctrl;
            log_n    = log_n + 1;
            log_last = sw_ctrl;
        end
        if (done) done_cnt = done_cnt + 1;
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Pass test on count 499..501 per the R5 band formula.
    function automatic bit band_ok(int n, int cfg);
        int lk, hk, lo, hi;
        lk = (cfg == 0) ? 978  : (cfg == 1) ? 981  : 947;
        hk = (cfg == 0) ? 1085 : (cfg == 1) ? 1080 : 1054;
        lo = (n * lk) / 1024;
        hi = (n * hk) / 1024;
        return (lo <= 499) && (hi >= 501);
    endfunction

    function automatic int exp_vec(int n);
        return {29'd0, !band_ok(n, 2), !band_ok(n, 1), !band_ok(n, 0)};
    endfunction

    task automatic set_nom(int n);
        nom_cfg_a = 16'(n); nom_cfg_b = 16'(n); nom_cfg_c = 16'(n);
    endtask

    // Pulses start, optionally again mid-run, and waits for done.
    task automatic run_seq(int restart_at);
        int len;
        @(negedge clk);
        log_n    = 0;
        log_last = sw_ctrl;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        len   = 0;
        while (!done && len < 40000) begin
            @(negedge clk);
            len++;
            if (len == restart_at) start = 1'b1;
            else                   start = 1'b0;
        end
        start    = 1'b0;
        last_len = len;
        @(negedge clk);
        check("R7 done lasts one cycle", int'(done), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 reset sw_ctrl", int'(sw_ctrl), int'(E_NORM));
        check("R1 reset busy", int'(busy), 0);
        check("R1 reset done", int'(done), 0);
        check("R1 reset fail_vec", int'(fail_vec), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle sw_ctrl", int'(sw_ctrl), int'(E_NORM));
    endtask

    task automatic t_all_pass;
        int d0;
        osc_mode = 0; self_test = 1'b0; set_nom(500);
        d0 = done_cnt;
        run_seq(-1);
        ref_len = last_len;
        check("R3 R4 R5 all configs pass after settle burst", int'(fail_vec), exp_vec(500));
        check("R2 switch change count", log_n, 4);
        check("R2 first encoding A", int'(sw_log[0]), int'(E_A));
        check("R2 second encoding B", int'(sw_log[1]), int'(E_B));
        check("R2 third encoding C", int'(sw_log[2]), int'(E_C));
        check("R2 back to normal", int'(sw_log[3]), int'(E_NORM));
        check("R7 one done pulse", done_cnt - d0, 1);
        check("R1 busy low after run", int'(busy), 0);
        repeat (50) @(negedge clk);
        check("R7 result held", int'(fail_vec), exp_vec(500));
    endtask

    task automatic t_high_side;
        osc_mode = 0; set_nom(480);
        run_seq(-1);
        check("R5 asymmetric high side", int'(fail_vec), exp_vec(480));
        check("R5 high side vector is C only", int'(fail_vec), 3'b100);
    endtask

    task automatic t_low_side;
        osc_mode = 0; set_nom(530);
        run_seq(-1);
        check("R5 asymmetric low side", int'(fail_vec), exp_vec(530));
        check("R5 low side vector is A and B", int'(fail_vec), 3'b011);
    endtask

    task automatic t_loss_b;
        osc_mode = 2; set_nom(500);
        run_seq(-1);
        check("R6 R7 loss of oscillation in B", int'(fail_vec), 3'b010);
    endtask

    task automatic t_zero_nominal;
        osc_mode = 1; set_nom(0);
        run_seq(-1);
        check("R6 zero count fails with zero nominal", int'(fail_vec), 3'b111);
    endtask

    task automatic t_self_dead_osc;
        osc_mode = 1; set_nom(500); self_test = 1'b1;
        run_seq(-1);
        self_test = 1'b0;
        check("R8 self check uses internal reference", int'(st_fail), 0);
        check("R8 configs still run after self pass", int'(fail_vec), 3'b111);
        check("R8 switches normal during self phase", int'(sw_log[0]), int'(E_A));
        check("R8 self phase lengthens the run", int'(last_len > ref_len), 1);
    endtask

    task automatic t_self_live;
        osc_mode = 0; set_nom(500); self_test = 1'b1;
        run_seq(-1);
        self_test = 1'b0;
        check("R8 self pass with live oscillator", int'(st_fail), 0);
        check("R8 results after self pass", int'(fail_vec), exp_vec(500));
    endtask

    task automatic t_busy_start;
        int d0;
        osc_mode = 0; set_nom(500);
        d0 = done_cnt;
        run_seq(3000);
        repeat (20) @(negedge clk);
        check("R9 run length unchanged by start", last_len, ref_len);
        check("R9 single done pulse", done_cnt - d0, 1);
        check("R9 idle after run", int'(busy), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_all_pass();
        t_high_side();
        t_low_side();
        t_loss_b();
        t_zero_nominal();
        t_self_dead_osc();
        t_self_live();
        t_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule